// File: doc/BRIEF.md
# 100BASE-TX Transmit Coding Path

This block turns the nibble-wide transmit stream of a media-independent interface into the three-level symbol stream that drives a 100BASE-TX MLT-3 line stage. It runs entirely in the 125 MHz bit clock domain. A one-cycle nibble strobe marks the cycle, one in every five, at which the transmit data, enable and error inputs are taken. Each sampled nibble becomes a 5-bit code group. The group is serialized MSB first and scrambled one bit at a time. The resulting bit stream is NRZI coded and mapped to a three-level line state. Framing is added automatically: an idle group between frames, a start delimiter pair in place of the first two preamble nibbles, and an end delimiter pair after the frame.

A bypass control lets a user feed 5-bit words that are already scrambled. The error input supplies the top bit and the data nibble the lower four. These words skip encoding, framing and scrambling and go straight to the line coder. Bypass is only legal while auto-negotiation is off. A configuration error output flags the case where both controls are set.

Top module: `txp100_pcs_tx`

## Requirements
- R1: While reset is held, line_sym is 2'b00 and cfg_err is 0, whatever the inputs are.
- R2: In normal mode, a nibble taken with tx_en low outside a frame produces the idle group 11111.
- R3: The first nibble taken with tx_en high after idle produces 11000. The next nibble produces 10001, whatever txd holds.
- R4: Later nibbles taken with tx_en high produce the data group for txd: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: A data nibble taken with tx_er high produces 00100 in place of its data group.
- R6: The first nibble taken with tx_en low after the data phase produces 01101. The next produces 00111. After that the path returns to idle.
- R7: The group sampled at a strobe edge leaves over the next five clock edges, MSB first, one bit per edge. In normal mode each bit is XORed with s[10]^s[8] of an 11-bit register s. s is loaded with 11'h7FF in reset and shifts left on every clock out of reset, taking s[10]^s[8] into s[0].
- R8: line_sym encodes 2'b00 as 0, 2'b01 as +1 and 2'b11 as -1, and never 2'b10. At an edge that sends a 1 bit the level steps along the cycle 0, +1, 0, -1. At an edge that sends a 0 bit it holds.
- R9: With bypass_en high at the strobe, the group is {tx_er, txd}, sent unscrambled. No delimiters are added, and the framing returns to idle.
- R10: cfg_err equals bypass_en AND autoneg_en as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_stb | input | 1 | One-cycle nibble sample strobe, every fifth cycle |
| txd | input | 4 | Transmit data nibble |
| tx_en | input | 1 | Transmit enable (frame in progress) |
| tx_er | input | 1 | Transmit error; code word MSB in bypass |
| bypass_en | input | 1 | Raw pre-scrambled word mode |
| autoneg_en | input | 1 | Auto-negotiation enabled indication |
| line_sym | output | 2 | Three-level line symbol |
| cfg_err | output | 1 | Bypass and auto-negotiation both enabled |

## Verification
The bench recovers bits from the level changes on the line and removes the scrambling with its own copy of the sequence. It then compares every 5-bit group against the group the requirements predict for the nibble taken at that strobe. Directed frames walk all sixteen data values, a one-nibble frame, back-to-back frames and an error inside a frame. These separate the data table, the delimiter pairs and the error substitution. Random frames with random gaps and error bits test the framing state changes. A random bypass phase with tx_en toggling shows that raw words pass unscrambled and unframed, and that cfg_err follows both controls.

// File: rtl/txp_pkg.sv
package txp_pkg;

    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_K    = 2'd1,
        ST_DATA = 2'd2,
        ST_R    = 2'd3
    } frm_st_e;

    localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [CG_W-1:0] CG_SSD1 = 5'b11000;
    localparam logic [CG_W-1:0] CG_SSD2 = 5'b10001;
    localparam logic [CG_W-1:0] CG_ESD1 = 5'b01101;
    localparam logic [CG_W-1:0] CG_ESD2 = 5'b00111;
    localparam logic [CG_W-1:0] CG_HALT = 5'b00100;

    function automatic logic [CG_W-1:0] nib_to_cg(input logic [NIB_W-1:0] n);
        logic [CG_W-1:0] c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/txp_framer.sv
module txp_framer
    import txp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic [NIB_W-1:0] txd_i,
    input  logic             tx_en_i,
    input  logic             tx_er_i,
    input  logic             bypass_i,
    output logic [CG_W-1:0]  cg_o
);

    typedef struct packed {
        frm_st_e st;
    } frm_s;

    frm_s frm_d, frm_q;

    always_comb begin
        frm_d = frm_q;
        cg_o  = CG_IDLE;
        if (bypass_i) begin
            cg_o     = {tx_er_i, txd_i};
            frm_d.st = ST_IDLE;
        end else begin
            case (frm_q.st)
                ST_IDLE: begin
                    if (tx_en_i) begin
                        cg_o     = CG_SSD1;
                        frm_d.st = ST_K;
                    end
                end
                ST_K: begin
                    cg_o     = CG_SSD2;
                    frm_d.st = ST_DATA;
                end
                ST_DATA: begin
                    if (tx_en_i) begin
                        cg_o = tx_er_i ? CG_HALT : nib_to_cg(txd_i);
                    end else begin
                        cg_o     = CG_ESD1;
                        frm_d.st = ST_R;
                    end
                end
                default: begin
                    cg_o     = CG_ESD2;
                    frm_d.st = ST_IDLE;
                end
            endcase
        end
        if (!stb_i) begin
            frm_d = frm_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q <= '{st: ST_IDLE};
        end else begin
            frm_q <= frm_d;
        end
    end

    // R3: a frame start always goes through the second delimiter state
    p_start_to_k_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !bypass_i && frm_q.st == ST_IDLE && tx_en_i) |=> (frm_q.st == ST_K));

    // R6: the second end delimiter is followed by idle
    p_end_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && frm_q.st == ST_R) |=> (frm_q.st == ST_IDLE));

    // R9: bypass keeps the framing at rest
    p_bypass_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && bypass_i) |=> (frm_q.st == ST_IDLE));

endmodule

// File: rtl/txp_serscr.sv
module txp_serscr
    import txp_pkg::*;
#(
    parameter int               LFSR_W = 11,
    parameter int               TAP_POS = 8,
    parameter logic [LFSR_W-1:0] SEED  = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb_i,
    input  logic [CG_W-1:0] cg_i,
    input  logic            raw_i,
    output logic            bit_o
);

    typedef struct packed {
        logic [CG_W-1:0]   sh;
        logic              raw;
        logic [LFSR_W-1:0] lfsr;
    } ser_s;

    ser_s ser_d, ser_q;
    logic key;

    always_comb begin
        ser_d     = ser_q;
        key       = ser_q.lfsr[LFSR_W-1] ^ ser_q.lfsr[TAP_POS];
        bit_o     = ser_q.sh[CG_W-1] ^ (key & ~ser_q.raw);
        ser_d.lfsr = {ser_q.lfsr[LFSR_W-2:0], key};
        if (stb_i) begin
            ser_d.sh  = cg_i;
            ser_d.raw = raw_i;
        end else begin
            ser_d.sh  = {ser_q.sh[CG_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_q <= '{sh: '0, raw: 1'b0, lfsr: SEED};
        end else begin
            ser_q <= ser_d;
        end
    end

    // R7: the scrambler sequence never collapses to the all-zero lock-up state
    p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_q.lfsr != '0);

endmodule

// File: rtl/txp_mlt3.sv
module txp_mlt3 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_i,
    output logic [1:0] line_sym_o
);

    typedef struct packed {
        logic       nrzi;
        logic [1:0] phase;
    } mlt_s;

    mlt_s mlt_d, mlt_q;

    always_comb begin
        mlt_d      = mlt_q;
        mlt_d.nrzi = mlt_q.nrzi ^ bit_i;
        if (mlt_d.nrzi != mlt_q.nrzi) begin
            mlt_d.phase = mlt_q.phase + 2'd1;
        end
    end

    always_comb begin
        case (mlt_q.phase)
            2'd1:    line_sym_o = 2'b01;
            2'd3:    line_sym_o = 2'b11;
            default: line_sym_o = 2'b00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mlt_q <= '{nrzi: 1'b0, phase: 2'd0};
        end else begin
            mlt_q <= mlt_d;
        end
    end

    // R8: the unused symbol code never appears
    p_no_bad_sym_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_sym_o != 2'b10);

    // R8: a zero bit holds the line level
    p_zero_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_i |=> $stable(line_sym_o));

    // R8: a one bit always moves the line level
    p_one_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_i |=> !$stable(line_sym_o));

endmodule

// File: rtl/txp100_pcs_tx.sv
module txp100_pcs_tx
    import txp_pkg::*;
#(
    parameter int                LFSR_W  = 11,
    parameter int                TAP_POS = 8,
    parameter logic [LFSR_W-1:0] SEED    = 11'h7FF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nib_stb,
    input  logic [3:0] txd,
    input  logic       tx_en,
    input  logic       tx_er,
    input  logic       bypass_en,
    input  logic       autoneg_en,
    output logic [1:0] line_sym,
    output logic       cfg_err
);

    typedef struct packed {
        logic err;
    } top_s;

    top_s top_d, top_q;
    logic [CG_W-1:0] cg;
    logic            ser_bit;

    txp_framer u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_i    (nib_stb),
        .txd_i    (txd),
        .tx_en_i  (tx_en),
        .tx_er_i  (tx_er),
        .bypass_i (bypass_en),
        .cg_o     (cg)
    );

    txp_serscr #(
        .LFSR_W  (LFSR_W),
        .TAP_POS (TAP_POS),
        .SEED    (SEED)
    ) u_serscr (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (nib_stb),
        .cg_i  (cg),
        .raw_i (bypass_en),
        .bit_o (ser_bit)
    );

    txp_mlt3 u_mlt3 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_i      (ser_bit),
        .line_sym_o (line_sym)
    );

    always_comb begin
        top_d     = top_q;
        top_d.err = bypass_en & autoneg_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '{err: 1'b0};
        end else begin
            top_q <= top_d;
        end
    end

    assign cfg_err = top_q.err;

    // R10: the flag follows both controls one edge later
    p_cfg_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cfg_err == $past(bypass_en && autoneg_en)));

endmodule

// File: tb/txp100_pcs_tx_tb_top.sv
module txp100_pcs_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nib_stb = 1'b0;
    logic [3:0] txd = '0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic       bypass_en = 1'b0;
    logic       autoneg_en = 1'b0;
    logic [1:0] line_sym;
    logic       cfg_err;

    always #2 clk = ~clk;

    txp100_pcs_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .nib_stb    (nib_stb),
        .txd        (txd),
        .tx_en      (tx_en),
        .tx_er      (tx_er),
        .bypass_en  (bypass_en),
        .autoneg_en (autoneg_en),
        .line_sym   (line_sym),
        .cfg_err    (cfg_err)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    typedef enum int {M_IDLE, M_K, M_DATA, M_R} mst_e;
    mst_e mst = M_IDLE;

    logic [4:0] q_cg[$];
    bit         q_scr[$];
    string      q_tag[$];

    logic [10:0] lfsr_m;
    logic [1:0]  prev_line = 2'b00;
    int          phase_b = 0;
    int          arm = 0;
    int          nbit = 0;
    logic [4:0]  raw_acc = '0;
    logic [4:0]  pl_acc = '0;
    logic        exp_cfg = 1'b0;

    function automatic logic [1:0] lvl(input int p);
        case (p % 4)
            1:       return 2'b01;
            3:       return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [4:0] data_cg(input logic [3:0] d);
        case (d)
            4'h0: return 5'b11110;  4'h1: return 5'b01001;
            4'h2: return 5'b10100;  4'h3: return 5'b10101;
            4'h4: return 5'b01010;  4'h5: return 5'b01011;
            4'h6: return 5'b01110;  4'h7: return 5'b01111;
            4'h8: return 5'b10010;  4'h9: return 5'b10011;
            4'hA: return 5'b10110;  4'hB: return 5'b10111;
            4'hC: return 5'b11010;  4'hD: return 5'b11011;
            4'hE: return 5'b11100;  default: return 5'b11101;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic monitor();
        bit         b;
        logic       key;
        logic [4:0] got;
        if (!live) return;
        chk(cfg_err == exp_cfg, "R10", "cfg_err", cfg_err, exp_cfg);
        chk(line_sym != 2'b10, "R8", "symbol code", line_sym, 0);
        b = (line_sym != prev_line);
        if (b) begin
            phase_b = (phase_b + 1) % 4;
            chk(line_sym == lvl(phase_b), "R8", "level order", line_sym, lvl(phase_b));
        end
        prev_line = line_sym;
        key    = lfsr_m[10] ^ lfsr_m[8];
        lfsr_m = {lfsr_m[9:0], key};
        if (arm == 1) begin
            arm = 2;
        end else if (arm == 2) begin
            raw_acc = {raw_acc[3:0], b};
            pl_acc  = {pl_acc[3:0], b ^ key};
            nbit++;
            if (nbit == 5) begin
                nbit = 0;
                if (q_cg.size() == 0) begin
                    chk(1'b0, "R7", "group with no expectation", pl_acc, 0);
                end else begin
                    logic [4:0] e;
                    bit         s;
                    string      t;
                    e = q_cg.pop_front();
                    s = q_scr.pop_front();
                    t = q_tag.pop_front();
                    got = s ? pl_acc : raw_acc;
                    chk(got == e, t, "code group", got, e);
                end
            end
        end
    endtask

    task automatic push_expect(input bit en, input bit er, input logic [3:0] d, input bit byp);
        logic [4:0] e;
        string      t;
        if (byp) begin
            e = {er, d}; t = "R9"; mst = M_IDLE;
        end else begin
            case (mst)
                M_IDLE: if (en) begin e = 5'b11000; t = "R3"; mst = M_K; end
                        else begin e = 5'b11111; t = "R2"; end
                M_K: begin e = 5'b10001; t = "R3"; mst = M_DATA; end
                M_DATA: if (en) begin
                            e = er ? 5'b00100 : data_cg(d);
                            t = er ? "R5" : "R4";
                        end else begin
                            e = 5'b01101; t = "R6"; mst = M_R;
                        end
                default: begin e = 5'b00111; t = "R6"; mst = M_IDLE; end
            endcase
        end
        q_cg.push_back(e);
        q_scr.push_back(!byp);
        q_tag.push_back(t);
    endtask

    task automatic nib(input bit en, input bit er, input logic [3:0] d,
                       input bit byp, input bit an);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            monitor();
            if (k == 0) begin
                nib_stb    = 1'b1;
                tx_en      = en;
                tx_er      = er;
                txd        = d;
                bypass_en  = byp;
                autoneg_en = an;
                push_expect(en, er, d, byp);
                if (arm == 0) arm = 1;
            end else begin
                nib_stb = 1'b0;
            end
            exp_cfg = bypass_en & autoneg_en;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        // R1: reset holds the outputs quiet even with both controls set
        bypass_en  = 1'b1;
        autoneg_en = 1'b1;
        tx_en      = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(line_sym == 2'b00, "R1", "line_sym in reset", line_sym, 0);
            chk(cfg_err == 1'b0, "R1", "cfg_err in reset", cfg_err, 0);
        end
        @(negedge clk);
        bypass_en  = 1'b0;
        autoneg_en = 1'b0;
        tx_en      = 1'b0;
        rst_n      = 1'b1;
        lfsr_m     = 11'h7FF;
        live       = 1'b1;
        exp_cfg    = 1'b0;

        // R2 idle, then R3/R4 every data value, R6 close
        for (int i = 0; i < 3; i++) nib(0, 0, 4'h0, 0, 1);
        nib(1, 0, 4'h5, 0, 1);
        nib(1, 0, 4'h5, 0, 0);
        for (int i = 0; i < 16; i++) nib(1, 0, 4'(i), 0, 0);
        nib(0, 0, 4'h0, 0, 0);
        nib(0, 0, 4'h0, 0, 0);
        nib(0, 0, 4'h0, 0, 0);
        // R5 error inside a frame, R3 start ignores tx_er
        nib(1, 1, 4'h3, 0, 0);
        nib(1, 1, 4'h3, 0, 0);
        nib(1, 0, 4'hA, 0, 0);
        nib(1, 1, 4'hA, 0, 0);
        nib(1, 0, 4'h7, 0, 0);
        // R6 back-to-back: tx_en high again right after the end pair
        nib(0, 0, 4'h0, 0, 0);
        nib(1, 0, 4'h0, 0, 0);
        nib(1, 0, 4'h0, 0, 0);
        nib(1, 0, 4'h0, 0, 0);
        // one-nibble frame
        nib(1, 0, 4'h9, 0, 0);
        nib(0, 0, 4'h9, 0, 0);
        nib(0, 0, 4'h0, 0, 0);
        nib(0, 0, 4'h0, 0, 0);
        nib(0, 0, 4'h0, 0, 0);
        // random frames
        for (int f = 0; f < 25; f++) begin
            int gap = 1 + int'($urandom % 3);
            int len = 1 + int'($urandom % 20);
            for (int g = 0; g < gap; g++) nib(0, 0, 4'($urandom), 0, $urandom % 2);
            for (int i = 0; i < len; i++)
                nib(1, ($urandom % 8) == 0, 4'($urandom), 0, $urandom % 2);
        end
        for (int g = 0; g < 3; g++) nib(0, 0, 4'h0, 0, 0);
        // R9 bypass with random raw words, R10 flag toggling
        for (int i = 0; i < 40; i++)
            nib($urandom % 2, $urandom % 2, 4'($urandom), 1, $urandom % 2);
        // back to normal framing after bypass
        nib(0, 0, 4'h0, 0, 1);
        nib(1, 0, 4'h1, 0, 1);
        nib(1, 0, 4'h1, 0, 0);
        nib(1, 0, 4'hC, 0, 0);
        for (int g = 0; g < 4; g++) nib(0, 0, 4'h0, 0, 0);
        chk(q_cg.size() <= 1, "R7", "groups left unsent", q_cg.size(), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule